// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block owns a small shared word memory and serves several requesting processors through one request/response port each. Besides plain reads and writes it supports a load-linked operation, which returns a word and records a reservation for the requesting port, and a store-conditional, which writes only when that reservation is still intact and reports back whether it did.

Requests are presented level-sensitive. A fixed-priority grant, combinational on the request vector, picks one request per cycle, and the lowest port index wins. A requester holds its request until it sees its grant. The response (valid, status and read data) appears on the cycle after the grant. Every write that reaches memory removes the reservations that other ports hold on that word. This covers plain writes and successful store-conditionals. A plain write also removes the writer's own reservation on that word. A failed store-conditional leaves memory unchanged.

Top module: `llsc_monitor`

## Requirements
- R1: An operation code of 2'b00 is a read and 2'b01 is a plain write. A granted request gets `rsp_valid` on its own port bit exactly one cycle later. A read returns the stored word in `rsp_rdata`, and a write stores `req_wdata` at `req_addr`. Read, write and load-linked always respond with `rsp_ok`=1.
- R2: In a cycle, at most one port is granted. Only a port with its request valid can be granted. When several ports request in the same cycle, the lowest index is granted.
- R3: A load-linked (code 2'b10) returns the current word in `rsp_rdata` and records a reservation for the requesting port on that address.
- R4: A store-conditional (code 2'b11) stores its data and answers `rsp_ok`=1 only if the issuing port holds a reservation on exactly that address.
- R5: A store-conditional without a matching reservation answers `rsp_ok`=0 and leaves the memory word unchanged. This covers a port with no reservation and a port reserved on another address.
- R6: A plain write from any port, including the reservation holder, to a reserved address cancels every reservation on that address.
- R7: A successful store-conditional cancels the reservations other ports hold on the same address. When two ports issue store-conditionals to one word in the same cycle, the lower index succeeds and the other fails.
- R8: A store-conditional always cancels the issuing port's own reservation, whether it succeeds or fails.
- R9: Each port holds at most one reservation. A new load-linked replaces the previous one.
- R10: After reset no response is pending and no port holds a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request present, one bit per port |
| req_op | input | 2*NPORTS | Operation code per port (00 read, 01 write, 10 load-linked, 11 store-conditional) |
| req_addr | input | AW*NPORTS | Word address per port |
| req_wdata | input | DW*NPORTS | Write data per port |
| req_grant | output | NPORTS | Request accepted this cycle (one-hot or zero) |
| rsp_valid | output | NPORTS | Response for the port granted in the previous cycle |
| rsp_ok | output | 1 | Status of the response; 0 only for a failed store-conditional |
| rsp_rdata | output | DW | Word returned by a read or load-linked, zero otherwise |

## Verification
The hardest case to reach from the ports is two store-conditionals to one word, both holding valid reservations, arriving in the same cycle. Both ports first take load-linked reservations one after another. The bench then raises both store-conditional requests on the same falling edge and holds the higher-index request through the lower one's grant. The first store's commit then cancels the second reservation just before the second store is granted. Reservation cancellation by another port's write is reached the same way: a load-linked, then a write from a different port, then a store-conditional whose status and the memory word read back afterward show the effect.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } op_e;

  // width of a port index for a given port count
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // operation delivers a memory word in its response
  function automatic logic op_returns_data(input op_e op);
    return (op == OP_READ) || (op == OP_LL);
  endfunction

  // store-conditional may commit only on a valid reservation of the same word
  function automatic logic resv_matches(input logic held, input logic [63:0] held_addr,
                                        input logic [63:0] req_addr);
    return held && (held_addr == req_addr);
  endfunction

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int N = 3,
  localparam int IDW = llsc_pkg::idx_width(N)
) (
  input  logic [N-1:0]   req,
  output logic [N-1:0]   grant,
  output logic [IDW-1:0] sel,
  output logic           any
);
  always_comb begin
    grant = '0;
    sel   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        sel      = IDW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
  parameter int N  = 3,
  parameter int AW = 6,
  localparam int IDW = llsc_pkg::idx_width(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_fire,
  input  logic [IDW-1:0]    op_sel,
  input  llsc_pkg::op_e     op_code,
  input  logic [AW-1:0]     op_addr,
  input  logic              mem_commit,
  output logic [N-1:0]      resv_valid,
  output logic [AW*N-1:0]   resv_addr
);
  import llsc_pkg::*;

  for (genvar gi = 0; gi < N; gi++) begin : g_port
    logic          own_op;
    logic          hits_word;
    logic [AW-1:0] addr_q;

    assign own_op    = op_fire && (op_sel == IDW'(gi));
    assign hits_word = resv_valid[gi] && (addr_q == op_addr);
    assign resv_addr[gi*AW +: AW] = addr_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        resv_valid[gi] <= 1'b0;
        addr_q         <= '0;
      end else if (own_op && op_code == OP_LL) begin
        resv_valid[gi] <= 1'b1;
        addr_q         <= op_addr;
      end else if (own_op && op_code == OP_SC) begin
        resv_valid[gi] <= 1'b0;
      end else if (mem_commit && hits_word) begin
        resv_valid[gi] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_store.sv
module llsc_store #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NPORTS = 3,
  parameter int AW     = 6,
  parameter int DW     = 32,
  localparam int IDW   = llsc_pkg::idx_width(NPORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_valid,
  input  logic [2*NPORTS-1:0]  req_op,
  input  logic [AW*NPORTS-1:0] req_addr,
  input  logic [DW*NPORTS-1:0] req_wdata,
  output logic [NPORTS-1:0]    req_grant,
  output logic [NPORTS-1:0]    rsp_valid,
  output logic                 rsp_ok,
  output logic [DW-1:0]        rsp_rdata
);
  import llsc_pkg::*;

  logic [NPORTS-1:0]    arb_req;
  logic [IDW-1:0]       sel;
  logic                 fire;
  op_e                  sel_op;
  logic [AW-1:0]        sel_addr;
  logic [DW-1:0]        sel_wdata;
  logic [NPORTS-1:0]    resv_valid;
  logic [AW*NPORTS-1:0] resv_addr_f;
  logic                 resv_hit;
  logic                 sc_pass;
  logic                 sc_fail;
  logic                 commit_we;
  logic [DW-1:0]        mem_q;
  logic                 data_rsp_q;

  assign arb_req = req_valid & {NPORTS{rst_n}};

  llsc_arbiter #(.N(NPORTS)) u_arb (
    .req   (arb_req),
    .grant (req_grant),
    .sel   (sel),
    .any   (fire)
  );

  always_comb begin
    sel_op    = op_e'(req_op[sel*2 +: 2]);
    sel_addr  = req_addr[sel*AW +: AW];
    sel_wdata = req_wdata[sel*DW +: DW];
    resv_hit  = resv_matches(resv_valid[sel], 64'(resv_addr_f[sel*AW +: AW]), 64'(sel_addr));
  end

  assign sc_pass   = fire && (sel_op == OP_SC) && resv_hit;
  assign sc_fail   = fire && (sel_op == OP_SC) && !resv_hit;
  assign commit_we = fire && ((sel_op == OP_WRITE) || sc_pass);

  llsc_resv_table #(.N(NPORTS), .AW(AW)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_fire    (fire),
    .op_sel     (sel),
    .op_code    (sel_op),
    .op_addr    (sel_addr),
    .mem_commit (commit_we),
    .resv_valid (resv_valid),
    .resv_addr  (resv_addr_f)
  );

  llsc_store #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (commit_we),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= '0;
      rsp_ok     <= 1'b0;
      data_rsp_q <= 1'b0;
    end else begin
      rsp_valid  <= req_grant;
      rsp_ok     <= fire && !sc_fail;
      data_rsp_q <= fire && op_returns_data(sel_op);
    end
  end

  assign rsp_rdata = data_rsp_q ? mem_q : '0;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int N  = 3,
  parameter int AW = 6,
  localparam int IDW = llsc_pkg::idx_width(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_valid,
  input logic [N-1:0]    req_grant,
  input logic [N-1:0]    rsp_valid,
  input logic            rsp_ok,
  input logic            fire,
  input logic [IDW-1:0]  sel,
  input logic [1:0]      sel_op,
  input logic [AW-1:0]   sel_addr,
  input logic [N-1:0]    resv_valid,
  input logic [AW*N-1:0] resv_addr_f,
  input logic            sc_pass,
  input logic            sc_fail
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant));

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);

  // R1
  rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid == $past(req_grant));

  // R4
  sc_pass_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |=> rsp_ok);

  // R5
  sc_fail_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fail |=> !rsp_ok);

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    localparam logic [N-1:0] LOWER = N'((1 << gi) - 1);

    // R2
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[gi] |-> (req_valid & LOWER) == '0);

    // R3
    ll_reserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel == IDW'(gi) && sel_op == 2'b10)
      |=> resv_valid[gi] && resv_addr_f[gi*AW +: AW] == $past(sel_addr));

    // R8
    sc_drops_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel == IDW'(gi) && sel_op == 2'b11) |=> !resv_valid[gi]);

    // R6
    write_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel_op == 2'b01 && resv_valid[gi] && resv_addr_f[gi*AW +: AW] == sel_addr)
      |=> !resv_valid[gi]);
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(.N(NPORTS), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_grant   (req_grant),
  .rsp_valid   (rsp_valid),
  .rsp_ok      (rsp_ok),
  .fire        (fire),
  .sel         (sel),
  .sel_op      (sel_op),
  .sel_addr    (sel_addr),
  .resv_valid  (resv_valid),
  .resv_addr_f (resv_addr_f),
  .sc_pass     (sc_pass),
  .sc_fail     (sc_fail)
);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, LL = 2'b10, SC = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    req_grant;
  logic [N-1:0]    rsp_valid;
  logic            rsp_ok;
  logic [DW-1:0]   rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  llsc_monitor #(.NPORTS(N), .AW(AW), .DW(DW)) u0 (.*);

  task automatic check(input bit cond, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    req_op[p*2 +: 2]     = op;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = d;
    req_valid[p]         = 1'b1;
  endtask

  // one request on one port; returns status and data of its response
  task automatic do_op(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic ok, output logic [DW-1:0] rd);
    @(negedge clk);
    drive(p, op, a, d);
    #1;
    while (!req_grant[p]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid[p] = 1'b0;
    check(rsp_valid == N'(1 << p), "R1", "response on own port one cycle after grant",
          DW'(rsp_valid), DW'(1 << p));
    ok = rsp_ok;
    rd = rsp_rdata;
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] rd);
    logic ok;
    do_op(2, RD, a, '0, ok, rd);
  endtask

  task automatic t_reset;
    logic ok;
    logic [DW-1:0] rd;
    check(rsp_valid == '0, "R10", "no response after reset", DW'(rsp_valid), 0);
    check(req_grant == '0, "R2", "no grant without request", DW'(req_grant), 0);
    do_op(0, WR, 6'd3, 32'h0000_1111, ok, rd);
    do_op(1, SC, 6'd3, 32'hDEAD_0001, ok, rd);
    check(ok == 1'b0, "R10", "no reservation after reset, SC fails", DW'(ok), 0);
    read_word(6'd3, rd);
    check(rd == 32'h0000_1111, "R5", "failed SC leaves word", rd, 32'h0000_1111);
  endtask

  task automatic t_read_write;
    logic ok;
    logic [DW-1:0] rd;
    do_op(1, WR, 6'd10, 32'hCAFE_F00D, ok, rd);
    check(ok == 1'b1, "R1", "write status", DW'(ok), 1);
    do_op(0, WR, 6'd63, 32'h1234_5678, ok, rd);
    read_word(6'd10, rd);
    check(rd == 32'hCAFE_F00D, "R1", "read back word 10", rd, 32'hCAFE_F00D);
    read_word(6'd63, rd);
    check(rd == 32'h1234_5678, "R1", "read back top word", rd, 32'h1234_5678);
  endtask

  task automatic t_ll_sc_ok;
    logic ok;
    logic [DW-1:0] rd;
    do_op(0, LL, 6'd10, '0, ok, rd);
    check(rd == 32'hCAFE_F00D && ok, "R3", "LL returns word", rd, 32'hCAFE_F00D);
    do_op(0, SC, 6'd10, 32'hAAAA_0001, ok, rd);
    check(ok == 1'b1, "R4", "SC with reservation succeeds", DW'(ok), 1);
    read_word(6'd10, rd);
    check(rd == 32'hAAAA_0001, "R4", "SC data stored", rd, 32'hAAAA_0001);
    do_op(0, SC, 6'd10, 32'hBBBB_0002, ok, rd);
    check(ok == 1'b0, "R8", "second SC fails, reservation consumed", DW'(ok), 0);
    read_word(6'd10, rd);
    check(rd == 32'hAAAA_0001, "R5", "failed SC leaves word", rd, 32'hAAAA_0001);
  endtask

  task automatic t_other_write;
    logic ok;
    logic [DW-1:0] rd;
    do_op(1, LL, 6'd20, '0, ok, rd);
    do_op(2, WR, 6'd20, 32'h0000_2020, ok, rd);
    do_op(1, SC, 6'd20, 32'hBAD0_0020, ok, rd);
    check(ok == 1'b0, "R6", "other-port write cancels reservation", DW'(ok), 0);
    read_word(6'd20, rd);
    check(rd == 32'h0000_2020, "R6", "word keeps plain write", rd, 32'h0000_2020);
    do_op(1, LL, 6'd21, '0, ok, rd);
    do_op(2, WR, 6'd22, 32'h0000_2222, ok, rd);
    do_op(1, SC, 6'd21, 32'h0000_2121, ok, rd);
    check(ok == 1'b1, "R4", "write elsewhere keeps reservation", DW'(ok), 1);
    do_op(0, LL, 6'd23, '0, ok, rd);
    do_op(0, WR, 6'd23, 32'h0000_2323, ok, rd);
    do_op(0, SC, 6'd23, 32'hBAD0_0023, ok, rd);
    check(ok == 1'b0, "R6", "own plain write cancels reservation", DW'(ok), 0);
  endtask

  task automatic t_replace_and_mismatch;
    logic ok;
    logic [DW-1:0] rd;
    do_op(2, WR, 6'd30, 32'h0000_3030, ok, rd);
    do_op(2, LL, 6'd30, '0, ok, rd);
    do_op(2, LL, 6'd31, '0, ok, rd);
    do_op(2, SC, 6'd30, 32'hBAD0_0030, ok, rd);
    check(ok == 1'b0, "R9", "newer LL replaced old reservation", DW'(ok), 0);
    read_word(6'd30, rd);
    check(rd == 32'h0000_3030, "R5", "word untouched", rd, 32'h0000_3030);
    do_op(1, LL, 6'd32, '0, ok, rd);
    do_op(1, SC, 6'd33, 32'hBAD0_0033, ok, rd);
    check(ok == 1'b0, "R5", "SC to other address fails", DW'(ok), 0);
    do_op(1, SC, 6'd32, 32'hBAD0_0032, ok, rd);
    check(ok == 1'b0, "R8", "failed SC also dropped reservation", DW'(ok), 0);
  endtask

  task automatic t_sc_cancels_other;
    logic ok;
    logic [DW-1:0] rd;
    do_op(0, LL, 6'd40, '0, ok, rd);
    do_op(1, LL, 6'd40, '0, ok, rd);
    do_op(1, SC, 6'd40, 32'h0000_4141, ok, rd);
    check(ok == 1'b1, "R7", "first SC wins", DW'(ok), 1);
    do_op(0, SC, 6'd40, 32'hBAD0_0040, ok, rd);
    check(ok == 1'b0, "R7", "later SC loses after other commit", DW'(ok), 0);
    read_word(6'd40, rd);
    check(rd == 32'h0000_4141, "R7", "winner data kept", rd, 32'h0000_4141);
  endtask

  task automatic t_race;
    logic ok;
    logic [DW-1:0] rd;
    do_op(1, LL, 6'd50, '0, ok, rd);
    do_op(0, LL, 6'd50, '0, ok, rd);
    @(negedge clk);
    drive(0, SC, 6'd50, 32'h0000_5000);
    drive(1, SC, 6'd50, 32'h0000_5001);
    #1;
    check(req_grant == 3'b001, "R2", "lowest port granted first", DW'(req_grant), 1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    check(rsp_valid == 3'b001 && rsp_ok, "R7", "port 0 SC succeeds in race",
          DW'({rsp_valid, rsp_ok}), 32'h3);
    #1;
    check(req_grant == 3'b010, "R2", "held request granted next", DW'(req_grant), 2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    check(rsp_valid == 3'b010 && !rsp_ok, "R7", "port 1 SC fails in race",
          DW'({rsp_valid, rsp_ok}), 32'h4);
    read_word(6'd50, rd);
    check(rd == 32'h0000_5000, "R7", "race winner data kept", rd, 32'h0000_5000);
  endtask

  task automatic t_priority3;
    @(negedge clk);
    drive(2, RD, 6'd1, '0);
    drive(1, RD, 6'd1, '0);
    drive(0, RD, 6'd1, '0);
    #1;
    check(req_grant == 3'b001, "R2", "three requests, port 0 first", DW'(req_grant), 1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1;
    check(req_grant == 3'b010, "R2", "then port 1", DW'(req_grant), 2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    #1;
    check(req_grant == 3'b100, "R2", "then port 2", DW'(req_grant), 4);
    @(negedge clk);
    req_valid[2] = 1'b0;
    check(rsp_valid == 3'b100, "R1", "last response on port 2", DW'(rsp_valid), 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_write();
    t_ll_sc_ok();
    t_other_write();
    t_replace_and_mismatch();
    t_sc_cancels_other();
    t_race();
    t_priority3();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule